// File: doc/BRIEF.md
# Codec Power State Controller

This block holds the power state and the retained control registers of a voice codec. Instructions reach it over a three-wire serial control port: a chip-select, a serial clock and a data line. An instruction is either a single byte or a two-byte write. Every instruction carries a power flag, so any register write can also switch the codec on or off. A single byte that carries only a power command is also accepted.

The block runs on a free-running reference clock. It synchronises every external input into that clock domain. It watches the codec master clock, and when that clock stops toggling it forces a reset power-down. The block stays in that state until a fresh power-up instruction arrives. After any power-up, the transmit data output is held in high impedance until the second frame-sync pulse has been seen. The `dx_en` output tells the transmit serial port when it may drive.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After reset `pwr_up`, `rst_pd` and `dx_en` are 0, and control register i holds 8'hA0 + i.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts in one `sdi` bit, most significant bit first. A frame is evaluated when `cs_n` rises. A header byte holds the register address in bits 7:4, a data-follows flag in bit 1 and the power flag P in bit 0 (P = 0 means power up, P = 1 means power down). Bits 3:2 are don't-care.
- R3: An 8-bit frame whose data-follows flag is 0 is a power-only command. It applies P and changes no register.
- R4: A 16-bit frame whose header has the data-follows flag set writes the second byte into the addressed register and applies P.
- R5: An 8-bit frame with the data-follows flag set has no effect, and neither does a 16-bit frame with that flag clear.
- R6: A frame with any bit count other than 8 or 16 has no effect.
- R7: A write to an address of NUM_REGS or above changes no register, but its P flag is still applied.
- R8: Registers can be written in either power state, and they keep their contents across power-down.
- R9: If no master-clock transition is seen for LOSS_LIMIT reference cycles, the block drives `pwr_up` to 0, `rst_pd` to 1 and `dx_en` to 0.
- R10: Power-up commands are ignored while the master clock is lost. After the clock returns, the block stays powered down with `rst_pd` at 1 until a power-up command clears `rst_pd` and powers up.
- R11: After a power-up, `dx_en` stays 0 until the second rising edge of `fs`. It then stays 1 until the block powers down.
- R12: A power-up command received while the block is already powered up leaves `dx_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial control clock |
| cs_n | input | 1 | Serial control chip-select, active low |
| sdi | input | 1 | Serial control data |
| mclk | input | 1 | Codec master clock being monitored |
| fs | input | 1 | Transmit frame sync |
| pwr_up | output | 1 | 1 when the codec is powered up |
| rst_pd | output | 1 | 1 while in the reset power-down caused by clock loss |
| dx_en | output | 1 | Transmit data output may leave high impedance |
| regs | output | NUM_REGS*8 | Control register contents, register i at bits 8i+7:8i |

## Verification
The hardest state to reach from the ports is a master-clock loss that hits a fully powered-up codec with its output already enabled. Reaching it needs the whole sequence in place: a power-up, two frame syncs, and then a stop of `mclk` long enough to exceed the loss limit. The stimulus builds this in order. It then keeps working the control port while the clock is stopped, sending a power-up that must be refused and a register write that must land. Finally it restarts `mclk` and checks that only a new power-up instruction clears the reset power-down. A table of frames drives the decode rules, including truncated frames, wrong flag settings and out-of-range addresses.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  localparam int FRAME_SHORT = 8;
  localparam int FRAME_LONG  = 16;
  localparam int CNT_W       = 5;
  localparam int ADDR_W      = 4;

  typedef struct packed {
    logic              pwr_valid;
    logic              p;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
  } ctl_cmd_t;

  // Interpret a finished frame from its bit count and shift contents.
  function automatic ctl_cmd_t decode_frame(input logic [CNT_W-1:0] nbits,
                                            input logic [15:0] sh);
    ctl_cmd_t c;
    c = '0;
    if (nbits == CNT_W'(FRAME_SHORT) && !sh[1]) begin
      c.pwr_valid = 1'b1;
      c.p         = sh[0];
    end else if (nbits == CNT_W'(FRAME_LONG) && sh[9]) begin
      c.pwr_valid = 1'b1;
      c.p         = sh[8];
      c.wr_en     = 1'b1;
      c.addr      = sh[15:12];
      c.data      = sh[7:0];
    end
    return c;
  endfunction

  function automatic logic [7:0] reg_reset_value(input int idx);
    return 8'hA0 + 8'(idx);
  endfunction

endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
  parameter int             W       = 5,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cpc_serial_rx.sv
module cpc_serial_rx
  import cpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     cs_n_s,
  input  logic     sdi_s,
  output ctl_cmd_t cmd
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_LONG + 1);

  logic             sclk_q;
  logic             cs_q;
  logic [15:0]      shift;
  logic [CNT_W-1:0] cnt;

  wire sclk_rise = sclk_s & ~sclk_q;
  wire frame_end = cs_n_s & ~cs_q;
  wire bad_len   = (cnt != CNT_W'(FRAME_SHORT)) && (cnt != CNT_W'(FRAME_LONG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      shift  <= '0;
      cnt    <= '0;
      cmd    <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
      cmd    <= frame_end ? decode_frame(cnt, shift) : '0;
      if (cs_n_s) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        shift <= {shift[14:0], sdi_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  // R6
  bad_len_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && bad_len |=> !cmd.pwr_valid && !cmd.wr_en);

  // R2
  cmd_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !cmd.pwr_valid);

endmodule

// File: rtl/cpc_clk_monitor.sv
module cpc_clk_monitor #(
  parameter int LOSS_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_s,
  output logic lost
);

  localparam int CW = $clog2(LOSS_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LOSS_LIMIT);

  logic          mclk_q;
  logic [CW-1:0] idle_cnt;

  wire mclk_edge = mclk_s ^ mclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_q   <= 1'b0;
      idle_cnt <= '0;
    end else begin
      mclk_q <= mclk_s;
      if (mclk_edge)            idle_cnt <= '0;
      else if (idle_cnt != LIM) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign lost = (idle_cnt == LIM);

  // R9
  edge_clears_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_edge |=> !lost);

  // R9
  loss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost && !mclk_edge |=> lost);

endmodule

// File: rtl/cpc_power_seq.sv
module cpc_power_seq #(
  parameter int FS_WAIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_p,
  input  logic lost,
  input  logic fs_s,
  output logic pwr_up,
  output logic rst_pd,
  output logic dx_en
);

  localparam int FW = $clog2(FS_WAIT + 1);
  localparam logic [FW-1:0] FS_DONE = FW'(FS_WAIT);

  logic          fs_q;
  logic [FW-1:0] fs_cnt;

  wire fs_rise = fs_s & ~fs_q;
  wire up_req  = cmd_valid & ~cmd_p & ~lost;
  wire dn_req  = cmd_valid & cmd_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      pwr_up <= 1'b0;
      rst_pd <= 1'b0;
      fs_cnt <= '0;
    end else begin
      fs_q <= fs_s;
      if (lost) begin
        pwr_up <= 1'b0;
        rst_pd <= 1'b1;
      end else if (up_req) begin
        pwr_up <= 1'b1;
        rst_pd <= 1'b0;
      end else if (dn_req) begin
        pwr_up <= 1'b0;
      end
      if (!pwr_up)                           fs_cnt <= '0;
      else if (fs_rise && fs_cnt != FS_DONE) fs_cnt <= fs_cnt + 1'b1;
    end
  end

  assign dx_en = pwr_up && (fs_cnt == FS_DONE);

  // R9
  loss_forces_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !pwr_up && rst_pd);

  // R11
  dx_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dx_en |-> pwr_up);

  // R11
  dx_after_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_en) |-> $past(fs_rise));

  // R10
  rst_pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pd) |-> pwr_up);

  // R12
  dx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dx_en && !lost && !dn_req |=> dx_en);

endmodule

// File: rtl/cpc_regfile.sv
module cpc_regfile
  import cpc_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_o
);

  wire addr_oob = int'(wr_addr) >= NUM_REGS;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    wire hit = wr_en && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_o[i*8 +: 8] <= reg_reset_value(i);
      else if (hit) regs_o[i*8 +: 8] <= wr_data;
    end
  end

  // R8
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));

  // R7
  oob_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr_oob |=> $stable(regs_o));

endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import cpc_pkg::*;
#(
  parameter int NUM_REGS    = 6,
  parameter int LOSS_LIMIT  = 64,
  parameter int FS_WAIT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  sdi,
  input  logic                  mclk,
  input  logic                  fs,
  output logic                  pwr_up,
  output logic                  rst_pd,
  output logic                  dx_en,
  output logic [NUM_REGS*8-1:0] regs
);

  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] syn;
  ctl_cmd_t         cmd;
  logic             lost;

  assign raw_in = {fs, mclk, sdi, cs_n, sclk};

  cpc_sync #(
    .W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(5'b00010)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  cpc_serial_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(syn[0]), .cs_n_s(syn[1]), .sdi_s(syn[2]),
    .cmd(cmd)
  );

  cpc_clk_monitor #(.LOSS_LIMIT(LOSS_LIMIT)) u_mon (
    .clk(clk), .rst_n(rst_n), .mclk_s(syn[3]), .lost(lost)
  );

  cpc_power_seq #(.FS_WAIT(FS_WAIT)) u_pwr (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd.pwr_valid), .cmd_p(cmd.p), .lost(lost), .fs_s(syn[4]),
    .pwr_up(pwr_up), .rst_pd(rst_pd), .dx_en(dx_en)
  );

  cpc_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmd.wr_en), .wr_addr(cmd.addr), .wr_data(cmd.data),
    .regs_o(regs)
  );

endmodule

// File: tb/test_codec_pwr_ctrl.sv
`timescale 1ns/1ps
module test_codec_pwr_ctrl;

  localparam int NREG = 6;
  localparam int NVEC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, mclk = 1'b0, fs = 1'b0;
  logic mclk_run = 1'b1;
  logic pwr_up, rst_pd, dx_en;
  logic [NREG*8-1:0] regs;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  codec_pwr_ctrl i_codec_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .mclk(mclk), .fs(fs), .pwr_up(pwr_up), .rst_pd(rst_pd), .dx_en(dx_en),
    .regs(regs)
  );

  initial forever begin
    repeat (4) @(negedge clk);
    if (mclk_run) mclk = ~mclk;
  end

  // {bit count, frame, expected pwr_up, register index, expected value}
  localparam logic [32:0] VEC [NVEC] = '{
    {5'd8,  16'h0000, 1'b1, 3'd0, 8'hA0},  // R3 power up
    {5'd8,  16'h0001, 1'b0, 3'd1, 8'hA1},  // R3 power down
    {5'd16, 16'h225C, 1'b1, 3'd2, 8'h5C},  // R4 write + up
    {5'd16, 16'h3399, 1'b0, 3'd3, 8'h99},  // R4 write + down
    {5'd16, 16'h427E, 1'b1, 3'd4, 8'h7E},  // R4 R8 write in down state
    {5'd8,  16'h0003, 1'b1, 3'd4, 8'h7E},  // R5 header without data
    {5'd16, 16'h0111, 1'b1, 3'd0, 8'hA0},  // R5 long frame, flag clear
    {5'd12, 16'h0001, 1'b1, 3'd0, 8'hA0},  // R6 12 bits
    {5'd9,  16'h0001, 1'b1, 3'd1, 8'hA1},  // R6 9 bits
    {5'd16, 16'h7344, 1'b0, 3'd5, 8'hA5},  // R7 out of range, P applied
    {5'd16, 16'h7244, 1'b1, 3'd1, 8'hA1},  // R7 out of range, up
    {5'd8,  16'h0001, 1'b0, 3'd2, 8'h5C},  // R8 retained in down
    {5'd8,  16'h0001, 1'b0, 3'd3, 8'h99},  // R8 retained, repeat down
    {5'd16, 16'h5A3C, 1'b1, 3'd5, 8'h3C},  // R2 don't-care bits set
    {5'd8,  16'h000D, 1'b0, 3'd4, 8'h7E},  // R2 R3 don't-care bits set
    {5'd16, 16'hF201, 1'b1, 3'd0, 8'hA0}   // R7 address 15
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input int n, input logic [15:0] w);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      sclk = 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_fs();
    fs = 1'b1;
    repeat (4) @(negedge clk);
    fs = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 pwr_up", 64'(pwr_up), 64'd0);
    check("R1 rst_pd", 64'(rst_pd), 64'd0);
    check("R1 dx_en", 64'(dx_en), 64'd0);
    for (int i = 0; i < NREG; i++)
      check("R1 register default", 64'(regs[i*8 +: 8]), 64'(8'hA0 + 8'(i)));

    for (int v = 0; v < NVEC; v++) begin
      send(int'(VEC[v][32:28]), VEC[v][27:12]);
      check($sformatf("vector %0d pwr_up", v), 64'(pwr_up), 64'(VEC[v][11]));
      check($sformatf("vector %0d reg", v),
            64'(regs[int'(VEC[v][10:8])*8 +: 8]), 64'(VEC[v][7:0]));
    end

    // R11 output enable waits for the second frame sync
    send(8, 16'h0001);
    send(8, 16'h0000);
    check("R11 dx_en after power-up", 64'(dx_en), 64'd0);
    pulse_fs();
    check("R11 dx_en after first fs", 64'(dx_en), 64'd0);
    pulse_fs();
    check("R11 dx_en after second fs", 64'(dx_en), 64'd1);
    // R12 repeated power-up
    send(8, 16'h0000);
    check("R12 dx_en after repeat up", 64'(dx_en), 64'd1);
    pulse_fs();
    check("R11 dx_en after third fs", 64'(dx_en), 64'd1);
    send(8, 16'h0001);
    check("R11 dx_en after down", 64'(dx_en), 64'd0);

    // R9 master clock loss from an enabled state
    send(8, 16'h0000);
    pulse_fs();
    pulse_fs();
    check("R9 dx_en before loss", 64'(dx_en), 64'd1);
    mclk_run = 1'b0;
    repeat (100) @(negedge clk);
    check("R9 pwr_up on loss", 64'(pwr_up), 64'd0);
    check("R9 rst_pd on loss", 64'(rst_pd), 64'd1);
    check("R9 dx_en on loss", 64'(dx_en), 64'd0);
    // R10 power-up refused while lost
    send(8, 16'h0000);
    check("R10 pwr_up while lost", 64'(pwr_up), 64'd0);
    // R8 write still accepted while lost
    send(16, 16'h1A6B);
    check("R8 write while lost", 64'(regs[15:8]), 64'h6B);
    check("R10 rst_pd after write", 64'(rst_pd), 64'd1);
    mclk_run = 1'b1;
    repeat (30) @(negedge clk);
    check("R10 pwr_up after clock return", 64'(pwr_up), 64'd0);
    check("R10 rst_pd after clock return", 64'(rst_pd), 64'd1);
    send(8, 16'h0000);
    check("R10 pwr_up after new up", 64'(pwr_up), 64'd1);
    check("R10 rst_pd after new up", 64'(rst_pd), 64'd0);
    check("R11 dx_en after recovery", 64'(dx_en), 64'd0);
    check("R8 register kept", 64'(regs[23:16]), 64'h5C);

    finish_run();
  end

endmodule